// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

The mailbox lets several processors pass 32-bit messages to one another through a bank of small hardware queues. A processor writes a queue's message register to post a message and reads the same register to take the oldest one. For each queue, one register tells whether it is full and another gives how many messages it holds. Every push raises a "new message" event and every pop that takes a message out raises a "space available" event for that queue. Both events are recorded in the interrupt-status register of every user.

Each user owns an interrupt-status register and an enable register. The status bits stay set until software writes 1 to them. A user's interrupt line is high while any status bit is set together with its enable bit. A read-only revision register, a configuration register with two stored idle-mode bits and a read-only reset-done status complete the map. Accesses go through a single-cycle port with valid, write and read strobes. Read data is combinational in the cycle of the access, and a pop takes effect at the clock edge that ends that cycle.

Top module: `mbox_hub`

## Requirements
- R1: After reset every queue is empty, every interrupt-status, enable and configuration bit is 0, and every interrupt output is low.
- R2: A queue returns its messages in the order they were pushed. Its message-status register at 0xC0+4*q reads the number of messages held.
- R3: Each queue holds 4 messages. A push to a full queue is dropped. The FIFO-status register at 0x80+4*q reads 1 when the queue is full and 0 otherwise.
- R4: A read of the message register 0x40+4*q on an empty queue returns 0 and leaves the count at 0.
- R5: Offset 0x00 reads the revision constant and ignores writes. Offset 0x10 stores bit 0 (auto-idle) and bit 4 (smart-idle), and its other bits read 0. Offset 0x14 reads 1 (reset done).
- R6: A push accepted into queue q sets bit 2*q in the status register of every user (0x100+8*u). The bit stays set after the queue drains.
- R7: A pop that removes a message from queue q sets bit 2*q+1 in every user's status register. A pop on an empty queue sets no bit.
- R8: Writing 1 to a status bit clears it. A bit written with 0 keeps its value.
- R9: The enable register at 0x104+8*u is read/write over bits 0..11. irq_o[u] is high exactly when some bit is set in both user u's status and enable registers.
- R10: Offsets that name no register (including misaligned ones and queue slots 6..15) read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register (same cycle) |
| irq_o | output | 4 | One interrupt line per user |

## Verification
A corrupted queue pointer or count shows up on the first read of that queue: the message comes out of order, a dropped push appears, or the message-status value is wrong in the same cycle. A status bit that is lost or left stuck is visible in the next status read and, if the bit is enabled, on irq_o one cycle after the event that should have set or cleared it. Because events reach every user, one wrong bit in a single user's register differs from its neighbours and is caught by reading more than one user.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned OFS_REV = 'h000;
  localparam int unsigned OFS_CFG = 'h010;
  localparam int unsigned OFS_SYS = 'h014;
  localparam int unsigned OFS_MSG = 'h040;
  localparam int unsigned OFS_FST = 'h080;
  localparam int unsigned OFS_MST = 'h0C0;
  localparam int unsigned OFS_USR = 'h100;
  localparam int unsigned USR_STRIDE = 8;
  localparam int unsigned CFG_AUTO_BIT  = 0;
  localparam int unsigned CFG_SMART_BIT = 4;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode import mbox_pkg::*; #(
  parameter int unsigned NQ = 6,
  parameter int unsigned NU = 4,
  parameter int unsigned AW = 9
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_rev_o,
  output logic          hit_cfg_o,
  output logic          hit_sys_o,
  output logic [NQ-1:0] msg_sel_o,
  output logic [NQ-1:0] fst_sel_o,
  output logic [NQ-1:0] mst_sel_o,
  output logic [NU-1:0] sts_sel_o,
  output logic [NU-1:0] ena_sel_o
);
  assign hit_rev_o = (addr_i == AW'(OFS_REV));
  assign hit_cfg_o = (addr_i == AW'(OFS_CFG));
  assign hit_sys_o = (addr_i == AW'(OFS_SYS));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign msg_sel_o[q] = (addr_i == AW'(OFS_MSG + 4 * q));
    assign fst_sel_o[q] = (addr_i == AW'(OFS_FST + 4 * q));
    assign mst_sel_o[q] = (addr_i == AW'(OFS_MST + 4 * q));
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    assign sts_sel_o[u] = (addr_i == AW'(OFS_USR + USR_STRIDE * u));
    assign ena_sel_o[u] = (addr_i == AW'(OFS_USR + USR_STRIDE * u + 4));
  end
endmodule

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          pushed_o,
  output logic          popped_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o   = (cnt_q == CW'(DEPTH));
  assign pushed_o = push_i && !full_o;
  assign popped_o = pop_i && (cnt_q != '0);
  assign count_o  = cnt_q;
  assign head_o   = (cnt_q != '0) ? mem_q[rptr_q] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pushed_o) wptr_q <= bump(wptr_q);
      if (popped_o) rptr_q <= bump(rptr_q);
      cnt_q <= cnt_q + CW'(pushed_o) - CW'(popped_o);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (pushed_o && wptr_q == PW'(i)) mem_q[i] <= data_i;
    end
  end
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int unsigned EW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [EW-1:0] set_i,
  input  logic          clr_we_i,
  input  logic          en_we_i,
  input  logic [EW-1:0] wdata_i,
  output logic [EW-1:0] status_o,
  output logic [EW-1:0] enable_o,
  output logic          irq_o
);
  logic [EW-1:0] st_q, en_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      // new events win over a simultaneous clear
      st_q <= (st_q & ~clr_mask) | set_i;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = |(st_q & en_q);
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub import mbox_pkg::*; #(
  parameter int unsigned NQ     = 6,
  parameter int unsigned NU     = 4,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 9,
  parameter logic [31:0] REV_ID = 32'h0002_0107,
  localparam int unsigned EW    = 2 * NQ,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NU-1:0] irq_o
);
  logic          hit_rev, hit_cfg, hit_sys;
  logic [NQ-1:0] msg_sel, fst_sel, mst_sel;
  logic [NU-1:0] sts_sel, ena_sel;
  logic          wr, rd;

  logic [NQ*DW-1:0] head_flat;
  logic [NQ*CW-1:0] q_cnt_flat;
  logic [NQ-1:0]    q_full, q_pushed, q_popped;
  logic [EW-1:0]    evt_set;
  logic [NU*EW-1:0] st_flat, en_flat;
  logic             cfg_auto_q, cfg_smart_q;
  logic             unused_wdata;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;
  assign unused_wdata = ^wdata_i[DW-1:EW];

  mbox_decode #(.NQ(NQ), .NU(NU), .AW(AW)) i_decode (
    .addr_i   (addr_i),
    .hit_rev_o(hit_rev),
    .hit_cfg_o(hit_cfg),
    .hit_sys_o(hit_sys),
    .msg_sel_o(msg_sel),
    .fst_sel_o(fst_sel),
    .mst_sel_o(mst_sel),
    .sts_sel_o(sts_sel),
    .ena_sel_o(ena_sel)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    mbox_queue #(.DW(DW), .DEPTH(DEPTH)) i_queue (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (wr && msg_sel[q]),
      .pop_i   (rd && msg_sel[q]),
      .data_i  (wdata_i),
      .head_o  (head_flat[q*DW +: DW]),
      .count_o (q_cnt_flat[q*CW +: CW]),
      .full_o  (q_full[q]),
      .pushed_o(q_pushed[q]),
      .popped_o(q_popped[q])
    );
    assign evt_set[2*q]   = q_pushed[q];
    assign evt_set[2*q+1] = q_popped[q];
  end

  for (genvar u = 0; u < NU; u++) begin : g_user
    mbox_user_irq #(.EW(EW)) i_user (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (evt_set),
      .clr_we_i(wr && sts_sel[u]),
      .en_we_i (wr && ena_sel[u]),
      .wdata_i (wdata_i[EW-1:0]),
      .status_o(st_flat[u*EW +: EW]),
      .enable_o(en_flat[u*EW +: EW]),
      .irq_o   (irq_o[u])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_auto_q  <= 1'b0;
      cfg_smart_q <= 1'b0;
    end else if (wr && hit_cfg) begin
      cfg_auto_q  <= wdata_i[CFG_AUTO_BIT];
      cfg_smart_q <= wdata_i[CFG_SMART_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_rev) rdata_o = REV_ID;
    if (hit_cfg) begin
      rdata_o[CFG_AUTO_BIT]  = cfg_auto_q;
      rdata_o[CFG_SMART_BIT] = cfg_smart_q;
    end
    if (hit_sys) rdata_o = DW'(1);
    for (int q = 0; q < NQ; q++) begin
      if (msg_sel[q]) rdata_o = head_flat[q*DW +: DW];
      if (fst_sel[q]) rdata_o = DW'(q_full[q]);
      if (mst_sel[q]) rdata_o = DW'(q_cnt_flat[q*CW +: CW]);
    end
    for (int u = 0; u < NU; u++) begin
      if (sts_sel[u]) rdata_o = DW'(st_flat[u*EW +: EW]);
      if (ena_sel[u]) rdata_o = DW'(en_flat[u*EW +: EW]);
    end
  end
endmodule

// File: rtl/mbox_hub_chk.sv
module mbox_hub_chk import mbox_pkg::*; #(
  parameter int unsigned NQ    = 6,
  parameter int unsigned NU    = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 9,
  localparam int unsigned EW   = 2 * NQ,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [NU-1:0]    irq_o,
  input logic [NQ*CW-1:0] q_cnt_flat,
  input logic [NU*EW-1:0] st_flat,
  input logic [NU*EW-1:0] en_flat
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam logic [AW-1:0] MA = AW'(OFS_MSG + 4 * q);

    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_cnt_flat[q*CW +: CW] <= CW'(DEPTH)); // R2

    AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == MA && q_cnt_flat[q*CW +: CW] == CW'(DEPTH))
      |=> (q_cnt_flat[q*CW +: CW] == CW'(DEPTH))); // R3

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !we_i && addr_i == MA && q_cnt_flat[q*CW +: CW] == '0)
      |-> (rdata_o == '0)); // R4

    AST_EMPTY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !we_i && addr_i == MA && q_cnt_flat[q*CW +: CW] == '0)
      |=> (q_cnt_flat[q*CW +: CW] == '0)); // R4

    for (genvar u = 0; u < NU; u++) begin : g_u
      AST_NEWMSG_ALL_USERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && addr_i == MA && q_cnt_flat[q*CW +: CW] < CW'(DEPTH))
        |=> st_flat[u*EW + 2*q]); // R6

      AST_SPACE_ALL_USERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i && addr_i == MA && q_cnt_flat[q*CW +: CW] != '0)
        |=> st_flat[u*EW + 2*q + 1]); // R7
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_usr
    localparam logic [AW-1:0] SA = AW'(OFS_USR + USR_STRIDE * u);

    AST_W1C_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == SA && wdata_i[EW-1:0] == '1)
      |=> (st_flat[u*EW +: EW] == '0)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_flat[u*EW +: EW] == '0) |-> !irq_o[u]); // R9
  end
endmodule

bind mbox_hub mbox_hub_chk #(
  .NQ(NQ), .NU(NU), .DEPTH(DEPTH), .DW(DW), .AW(AW)
) i_mbox_hub_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .q_cnt_flat(q_cnt_flat),
  .st_flat   (st_flat),
  .en_flat   (en_flat)
);

// File: tb/test_mbox_hub.sv
module test_mbox_hub;
  localparam logic [31:0] REV = 32'h0002_0107;
  localparam int NV = 54;

  typedef struct packed {
    logic        we;
    logic        chk;
    logic [8:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // we, chk, addr, wdata, expected read, requirement
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 9'h000, 32'h0, REV, 4'd5},          // R5 revision
    '{1'b0, 1'b1, 9'h014, 32'h0, 32'h1, 4'd5},        // R5 reset done
    '{1'b1, 1'b0, 9'h010, 32'hFFFF_FFFF, 32'h0, 4'd5},
    '{1'b0, 1'b1, 9'h010, 32'h0, 32'h11, 4'd5},       // R5 only bits 0,4
    '{1'b1, 1'b0, 9'h010, 32'h0000_0010, 32'h0, 4'd5},
    '{1'b0, 1'b1, 9'h010, 32'h0, 32'h10, 4'd5},
    '{1'b1, 1'b0, 9'h000, 32'h0000_DEAD, 32'h0, 4'd5},
    '{1'b0, 1'b1, 9'h000, 32'h0, REV, 4'd5},          // R5 read-only
    '{1'b0, 1'b1, 9'h0C0, 32'h0, 32'h0, 4'd2},        // R2 empty
    '{1'b1, 1'b0, 9'h040, 32'h8000_00A1, 32'h0, 4'd2},
    '{1'b1, 1'b0, 9'h040, 32'h0000_00A2, 32'h0, 4'd2},
    '{1'b0, 1'b1, 9'h0C0, 32'h0, 32'h2, 4'd2},        // R2 count
    '{1'b0, 1'b1, 9'h080, 32'h0, 32'h0, 4'd3},        // R3 not full
    '{1'b0, 1'b1, 9'h100, 32'h0, 32'h1, 4'd6},        // R6 user0
    '{1'b0, 1'b1, 9'h118, 32'h0, 32'h1, 4'd6},        // R6 user3
    '{1'b0, 1'b1, 9'h040, 32'h0, 32'h8000_00A1, 4'd2},// R2 order
    '{1'b0, 1'b1, 9'h040, 32'h0, 32'h0000_00A2, 4'd2},
    '{1'b0, 1'b1, 9'h0C0, 32'h0, 32'h0, 4'd2},
    '{1'b0, 1'b1, 9'h108, 32'h0, 32'h3, 4'd7},        // R7 + sticky R6
    '{1'b0, 1'b1, 9'h040, 32'h0, 32'h0, 4'd4},        // R4 empty pop
    '{1'b0, 1'b1, 9'h0C0, 32'h0, 32'h0, 4'd4},
    '{1'b0, 1'b1, 9'h108, 32'h0, 32'h3, 4'd7},        // R7 empty pop no event
    '{1'b1, 1'b0, 9'h100, 32'h1, 32'h0, 4'd8},
    '{1'b0, 1'b1, 9'h100, 32'h0, 32'h2, 4'd8},        // R8 clear bit 0
    '{1'b1, 1'b0, 9'h100, 32'h0, 32'h0, 4'd8},
    '{1'b0, 1'b1, 9'h100, 32'h0, 32'h2, 4'd8},        // R8 zero keeps
    '{1'b1, 1'b0, 9'h054, 32'h51, 32'h0, 4'd3},
    '{1'b1, 1'b0, 9'h054, 32'h52, 32'h0, 4'd3},
    '{1'b1, 1'b0, 9'h054, 32'h53, 32'h0, 4'd3},
    '{1'b1, 1'b0, 9'h054, 32'h54, 32'h0, 4'd3},
    '{1'b1, 1'b0, 9'h054, 32'h55, 32'h0, 4'd3},       // dropped
    '{1'b0, 1'b1, 9'h094, 32'h0, 32'h1, 4'd3},        // R3 full
    '{1'b0, 1'b1, 9'h0D4, 32'h0, 32'h4, 4'd3},
    '{1'b0, 1'b1, 9'h054, 32'h0, 32'h51, 4'd3},
    '{1'b0, 1'b1, 9'h094, 32'h0, 32'h0, 4'd3},
    '{1'b0, 1'b1, 9'h054, 32'h0, 32'h52, 4'd3},
    '{1'b0, 1'b1, 9'h054, 32'h0, 32'h53, 4'd3},
    '{1'b0, 1'b1, 9'h054, 32'h0, 32'h54, 4'd3},
    '{1'b0, 1'b1, 9'h054, 32'h0, 32'h0, 4'd3},        // R3 fifth lost
    '{1'b1, 1'b0, 9'h020, 32'hFFFF, 32'h0, 4'd10},
    '{1'b0, 1'b1, 9'h020, 32'h0, 32'h0, 4'd10},       // R10
    '{1'b1, 1'b0, 9'h060, 32'h77, 32'h0, 4'd10},
    '{1'b0, 1'b1, 9'h060, 32'h0, 32'h0, 4'd10},
    '{1'b0, 1'b1, 9'h0D8, 32'h0, 32'h0, 4'd10},
    '{1'b1, 1'b0, 9'h042, 32'h99, 32'h0, 4'd10},
    '{1'b0, 1'b1, 9'h042, 32'h0, 32'h0, 4'd10},
    '{1'b0, 1'b1, 9'h0C4, 32'h0, 32'h0, 4'd10},
    '{1'b0, 1'b1, 9'h120, 32'h0, 32'h0, 4'd10},
    '{1'b0, 1'b1, 9'h110, 32'h0, 32'hC03, 4'd6},      // R6 R7 user2
    '{1'b0, 1'b1, 9'h100, 32'h0, 32'hC02, 4'd8},      // R8 user0 kept clear
    '{1'b1, 1'b0, 9'h10C, 32'h1, 32'h0, 4'd9},
    '{1'b0, 1'b1, 9'h10C, 32'h0, 32'h1, 4'd9},        // R9 enable rw
    '{1'b1, 1'b0, 9'h114, 32'hFFFF_FFFF, 32'h0, 4'd9},
    '{1'b0, 1'b1, 9'h114, 32'h0, 32'hFFF, 4'd9}       // R9 width
  };

  logic        clk, rst_n, req, we;
  logic [8:0]  addr;
  logic [31:0] wdata, rdata;
  logic [3:0]  irq;
  int          errors = 0, checks = 0;
  bit          timed_out = 0;

  mbox_hub #(.REV_ID(REV)) i_mbox_hub (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic c, input logic [8:0] a,
                        input logic [31:0] d, input logic [31:0] e, input string tag);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #5;
    if (c) check(tag, rdata, e);
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic check_irq(input logic [3:0] e, input string tag);
    @(negedge clk);
    #5 check(tag, 32'(irq), 32'(e));
  endtask

  initial begin
    req = 0; we = 0; addr = '0; wdata = '0; rst_n = 1'b0;
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_irq(4'b0000, "R1 irq after reset");
        access(1'b0, 1'b1, 9'h100, 0, 0, "R1 status after reset");
        access(1'b0, 1'b1, 9'h010, 0, 0, "R1 config after reset");

        for (int i = 0; i < NV; i++)
          access(TBL[i].we, TBL[i].chk, TBL[i].addr, TBL[i].wdata, TBL[i].exp,
                 $sformatf("R%0d row %0d", TBL[i].req, i));

        // user1: status bit0 set, enable bit0; user2: all enabled
        check_irq(4'b0110, "R9 irq pattern");
        access(1'b1, 1'b0, 9'h108, 32'h1, 0, "R8");
        check_irq(4'b0100, "R9 irq drops after clear");
        access(1'b1, 1'b0, 9'h114, 32'h0, 0, "R9");
        check_irq(4'b0000, "R9 irq masked");
        access(1'b1, 1'b0, 9'h048, 32'h5A, 0, "R6");
        access(1'b1, 1'b0, 9'h114, 32'h10, 0, "R9");
        check_irq(4'b0100, "R9 irq from queue2 push");

        // reset in the middle with state present
        access(1'b1, 1'b0, 9'h010, 32'h11, 0, "R1");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check_irq(4'b0000, "R1 irq after reset");
        access(1'b0, 1'b1, 9'h0C8, 0, 0, "R1 queue cleared");
        access(1'b0, 1'b1, 9'h110, 0, 0, "R1 status cleared");
        access(1'b0, 1'b1, 9'h114, 0, 0, "R1 enable cleared");
        access(1'b0, 1'b1, 9'h010, 0, 0, "R1 config cleared");
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule